// File: doc/BRIEF.md
# Display Link 7:1 Serializer

This block turns one 28-bit parallel display word per pixel clock into four serial data lanes and a fifth clock lane. The word holds 24 colour bits (8 red, 8 green, 8 blue) and four control bits: line sync, frame sync, data enable and one spare. Each lane carries seven bits per pixel period, so its bit rate is seven times the pixel rate. For example, an 85 MHz pixel clock gives 595 Mbit/s per lane. The supported pixel clock range is 20 to 85 MHz.

The whole block runs on a fast bit clock `clk`. This clock comes from outside and stays phase-aligned with the pixel clock, giving seven bit clocks per pixel period. The pixel clock `pix_clk` is sampled on `clk`. A strap input selects whether words are captured on its rising or its falling edge. Each captured word goes into a holding register. The next capture edge moves it into the lane shift registers, so all seven slots of a lane always come from one word.

An active-low power-down input disables every lane. The differential drivers are outside this block; here the lanes are single-bit outputs with a shared output-enable. While the enable is low, all lane outputs are held at 0.

Top module: `dlink_serializer`

## Requirements
- R1: Lane j carries word bits j*7 to j*7+6. Bit j*7+s of the word is output in slot s of lane j, for lanes 0 to 3 and slots 0 to 6.
- R2: Each pixel period has seven slots, one per `clk` cycle, and slot 0 comes first. Suppose a word is captured at the capture edge seen on `clk` cycle k. Its slot 0 is then driven on the outputs for the cycle after the following capture edge, which is cycle k+7.
- R3: The clock lane outputs the pattern 1,1,0,0,0,1,1 in slots 0 to 6 of every pixel period, so it has exactly one rising edge per period, between slot 4 and slot 5.
- R4: With `strobe_rise` = 1, the word is sampled on the `clk` edge where `pix_clk` is first seen high after being low. With `strobe_rise` = 0, it is sampled where `pix_clk` is first seen low after being high.
- R5: The holding register changes only on a capture edge, so no lane ever mixes bits of two words.
- R6: One `clk` cycle after `pd_n` is seen low, `ser_oe` is 0. It stays 0 while `pd_n` is low, whatever the inputs do.
- R7: After `pd_n` returns high, `ser_oe` stays 0 and the lanes stay at 0 until the first word captured after the release is loaded. That load happens at the second capture edge after the release. `ser_oe` rises together with slot 0 of that word.
- R8: After reset, `ser_oe`, `ser_clk` and all of `ser_data` are 0.
- R9: Whenever `ser_oe` is 0, `ser_data` and `ser_clk` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven cycles per pixel period |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, sampled on `clk` |
| strobe_rise | input | 1 | 1: capture on the rising pixel edge, 0: capture on the falling pixel edge |
| pd_n | input | 1 | Active-low power-down |
| pix_word | input | 28 | Parallel word: colour and control bits |
| ser_data | output | 4 | Serial data lanes, bit j is lane j |
| ser_clk | output | 1 | Clock lane |
| ser_oe | output | 1 | Output-enable for all five lanes |

## Verification
The word sequence starts with a walking one and a walking zero over all 28 positions. Each position then lands on exactly one lane and slot, so a swapped lane or a reversed slot order stands out (R1, R2). After that, words produced by an arithmetic recurrence exercise dense mixed patterns. The stimulus places two different words in each pixel period, one driven at the rising edge and one at the falling edge. Comparing the two strap settings then shows which edge was used for capture (R4). Each run contains a power-down window that begins and ends in the middle of a pixel period. This tests both the immediate shutdown and the wait for the second capture edge after release (R6, R7).

// File: rtl/dlink_pkg.sv
package dlink_pkg;

   parameter int DL_LANES = 4;
   parameter int DL_SLOTS = 7;

   // Clock-lane slot pattern, bit k is slot k (1,1,0,0,0,1,1)
   parameter logic [6:0] DL_CLK_PAT = 7'b1100011;

   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_sel_e;

endpackage

// File: rtl/dlink_word_capture.sv
module dlink_word_capture
   import dlink_pkg::*;
#(
   parameter int WORD_W = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_clk,
   input  logic              strobe_rise,
   input  logic              pd_n,
   input  logic [WORD_W-1:0] word_i,
   output logic              cap_o,
   output logic [WORD_W-1:0] word_o,
   output logic              valid_o
);

   if (WORD_W < 2) begin : g_bad_width
      $error("dlink_word_capture: WORD_W too small");
   end

   logic              pix_q;
   logic              rise_ev;
   logic              fall_ev;
   edge_sel_e         sel;
   logic [WORD_W-1:0] hold_q;
   logic              hold_vld_q;

   assign sel     = edge_sel_e'(strobe_rise);
   assign rise_ev = pix_clk & ~pix_q;
   assign fall_ev = ~pix_clk & pix_q;

   always_comb begin
      unique case (sel)
         EDGE_RISE: cap_o = rise_ev;
         default:   cap_o = fall_ev;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q      <= 1'b0;
         hold_q     <= '0;
         hold_vld_q <= 1'b0;
      end else begin
         pix_q <= pix_clk;
         if (cap_o) begin
            hold_q <= word_i;
         end
         if (!pd_n) begin
            hold_vld_q <= 1'b0;
         end else if (cap_o) begin
            hold_vld_q <= 1'b1;
         end
      end
   end

   assign word_o  = hold_q;
   assign valid_o = hold_vld_q;

   AST_HOLD_ONLY_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_o |=> $stable(hold_q)); // R5

endmodule

// File: rtl/dlink_lane_shift.sv
module dlink_lane_shift #(
   parameter int SLOTS = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [SLOTS-1:0] load_val,
   output logic             bit_o
);

   if (SLOTS < 2) begin : g_bad_slots
      $error("dlink_lane_shift: SLOTS must be at least 2");
   end

   logic [SLOTS-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (clr) begin
         sr_q <= '0;
      end else if (load) begin
         sr_q <= load_val;
      end else begin
         sr_q <= {1'b0, sr_q[SLOTS-1:1]};
      end
   end

   assign bit_o = sr_q[0];

endmodule

// File: rtl/dlink_serializer.sv
module dlink_serializer
   import dlink_pkg::*;
#(
   parameter int               LANES   = DL_LANES,
   parameter int               SLOTS   = DL_SLOTS,
   parameter logic [SLOTS-1:0] CLK_PAT = DL_CLK_PAT
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pix_clk,
   input  logic                   strobe_rise,
   input  logic                   pd_n,
   input  logic [LANES*SLOTS-1:0] pix_word,
   output logic [LANES-1:0]       ser_data,
   output logic                   ser_clk,
   output logic                   ser_oe
);

   localparam int               WORD_W = LANES * SLOTS;
   localparam int               SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1;
   localparam logic [SW-1:0]    LAST   = SW'(SLOTS - 1);

   if (LANES < 1) begin : g_bad_lanes
      $error("dlink_serializer: LANES must be at least 1");
   end
   if (CLK_PAT[0] != 1'b1 || CLK_PAT[SLOTS-1] != 1'b1) begin : g_bad_pat
      $error("dlink_serializer: clock pattern must start and end high");
   end

   logic              cap_ev;
   logic [WORD_W-1:0] held_word;
   logic              held_vld;
   logic              load;
   logic              oe_q;
   logic [SW-1:0]     slot_q;

   dlink_word_capture #(.WORD_W(WORD_W)) i_capture (
      .clk         (clk),
      .rst_n       (rst_n),
      .pix_clk     (pix_clk),
      .strobe_rise (strobe_rise),
      .pd_n        (pd_n),
      .word_i      (pix_word),
      .cap_o       (cap_ev),
      .word_o      (held_word),
      .valid_o     (held_vld)
   );

   assign load = cap_ev & held_vld & pd_n;

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      dlink_lane_shift #(.SLOTS(SLOTS)) i_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (~pd_n),
         .load     (load),
         .load_val (held_word[j*SLOTS +: SLOTS]),
         .bit_o    (ser_data[j])
      );
   end

   dlink_lane_shift #(.SLOTS(SLOTS)) i_clk_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (~pd_n),
      .load     (load),
      .load_val (CLK_PAT),
      .bit_o    (ser_clk)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q   <= 1'b0;
         slot_q <= '0;
      end else begin
         if (!pd_n) begin
            oe_q <= 1'b0;
         end else if (load) begin
            oe_q <= 1'b1;
         end
         if (load || slot_q == LAST) begin
            slot_q <= '0;
         end else begin
            slot_q <= slot_q + 1'b1;
         end
      end
   end

   assign ser_oe = oe_q;

   AST_PD_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_n |=> !ser_oe); // R6
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_oe |-> (ser_data == '0 && !ser_clk)); // R9
   AST_ENABLE_AT_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_oe) |-> slot_q == '0); // R7
   AST_CLK_RISE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_oe && $past(ser_oe) && $rose(ser_clk)) |-> CLK_PAT[slot_q]); // R3

endmodule

// File: tb/test_dlink_serializer.sv
module test_dlink_serializer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_clk = 1'b0;
   logic        strobe_rise = 1'b1;
   logic        pd_n = 1'b1;
   logic [27:0] pix_word = '0;
   logic [3:0]  ser_data;
   logic        ser_clk;
   logic        ser_oe;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 0;

   always #10 clk = ~clk;

   dlink_serializer i_dlink_serializer (
      .clk         (clk),
      .rst_n       (rst_n),
      .pix_clk     (pix_clk),
      .strobe_rise (strobe_rise),
      .pd_n        (pd_n),
      .pix_word    (pix_word),
      .ser_data    (ser_data),
      .ser_clk     (ser_clk),
      .ser_oe      (ser_oe)
   );

   localparam int NSTEP = 300;
   localparam int NPD   = 150;
   localparam int NREL  = 163;

   // word driven at the rising pixel edge of frame f
   function automatic logic [27:0] word_a(input int f);
      if (f < 28) return 28'(1) << f;
      return 28'(f * 28'h0B3C5D7 + 28'h5A5A5A5);
   endfunction

   // word driven at the falling pixel edge of frame f
   function automatic logic [27:0] word_b(input int f);
      if (f < 28) return ~(28'(1) << f);
      return ~word_a(f + 1000);
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run(input bit rise);
      int c0;
      c0 = rise ? 0 : 4;
      rst_n = 1'b0;
      pix_clk = 1'b0;
      pix_word = '0;
      pd_n = 1'b1;
      strobe_rise = rise;
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8", {5'd0, ser_oe, ser_clk, |ser_data}, 8'd0);
      rst_n = 1'b1;
      for (int n = 0; n < NSTEP; n++) begin
         @(negedge clk);
         begin
            int e, st, fc, s, ld, f;
            bit exp_oe;
            logic [3:0]  exp_d;
            logic        exp_c;
            logic [27:0] w;
            e = n - 1;
            exp_oe = 1'b0;
            exp_d = '0;
            exp_c = 1'b0;
            if (e >= 0 && !(e >= NPD && e < NREL)) begin
               st = (e >= NREL) ? NREL : 0;
               fc = st;
               while (fc % 7 != c0) fc++;
               exp_oe = (e >= fc + 7);
            end
            if (exp_oe) begin
               s  = (e - c0) % 7;
               ld = e - s;
               f  = (ld - 7) / 7;
               w  = rise ? word_a(f) : word_b(f);
               for (int j = 0; j < 4; j++) exp_d[j] = w[j*7 + s];
               exp_c = (s == 0 || s == 1 || s == 5 || s == 6);
            end
            // R6 R7 R8: enable follows reset, power-down and release
            check("R6 R7 oe", {7'd0, ser_oe}, {7'd0, exp_oe});
            // R1 R2 R4 R5: lane bits from one word at the chosen edge; R9 quiet when off
            check(rise ? "R1 R2 R4 R5 R9 rising" : "R1 R2 R4 R5 R9 falling",
                  {4'd0, ser_data}, {4'd0, exp_d});
            // R3: clock lane pattern
            check("R3 clk", {7'd0, ser_clk}, {7'd0, exp_c});
         end
         begin
            int p, f;
            p = n % 7;
            f = n / 7;
            pix_clk = (p < 4);
            if (p == 0) pix_word = word_a(f);
            if (p == 4) pix_word = word_b(f);
            pd_n = !(n >= NPD && n < NREL);
         end
      end
   endtask

   initial begin
      run(1'b1);
      run(1'b0);
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   end

endmodule